// File: doc/BRIEF.md
# MOESI Snooping Line Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. Each line is in one of five states: invalid, shared, exclusive, owned or modified. Processor reads and writes are resolved against the local copy. When the bus is needed, the controller issues a read, a read-for-ownership, an upgrade or a writeback. Transactions placed on the bus by other caches arrive as snoops and move local lines between states.

A wired shared handshake tells a reader whether any other cache keeps a copy. A fill that nobody else holds becomes exclusive, so a later write completes with no bus traffic. A modified line that another cache reads becomes owned. From then on, this cache supplies the dirty data to every reader and memory stays stale. The supplier flag tells the bus model that this cache, and not memory, answers the current transaction. The bus arbiter, the memory and the data array live outside the block.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: On a processor read miss the controller requests the bus with command code 0 (read) at the line address. The shared input is sampled one cycle after the grant: low gives an exclusive fill, high gives a shared fill.
- R2: In the cycle after a snooped read (code 0) that hits a valid local copy, the shared output is high. The output stays low for a snoop that misses or whose tags differ, and for every other command.
- R3: A processor write to an exclusive line completes with no bus request and leaves the line modified.
- R4: A snooped read that hits a modified line raises the supplier flag one cycle later and moves the line to owned. No writeback is issued.
- R5: An owned line raises the supplier flag on every snooped read and stays owned.
- R6: A snooped read-exclusive (code 1) that hits a modified or owned line raises the supplier flag and invalidates the line.
- R7: A processor write to a shared or owned line issues an upgrade (code 2) and leaves the line modified.
- R8: A snooped read moves an exclusive line to shared. A snooped read-exclusive or upgrade invalidates an exclusive, shared or owned copy, and only modified or owned copies supply data.
- R9: A miss that replaces a modified or owned line first issues a writeback (code 3) of the victim. A miss that replaces an exclusive, shared or invalid line issues no writeback.
- R10: The shared input affects a fill only in the cycle after the grant of a read. Its value in the grant cycle is ignored.
- R11: A processor write miss issues a read-exclusive and leaves the line modified. A read hit completes with no bus request. The done output pulses for exactly one cycle per request.
- R12: After reset every line is invalid, and the bus request, done, shared and supplier outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request strobe, one cycle, while idle |
| cpuWr | input | 1 | Request is a write |
| cpuAddr | input | AW | Block address of the request |
| cpuDone | output | 1 | Request finished, one-cycle pulse |
| busReq | output | 1 | Bus request, held until granted |
| busCmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| busAddr | output | AW | Block address of the bus request |
| busGnt | input | 1 | Grant; the cycle it is high is the address phase |
| shrIn | input | 1 | Wired shared line from the other caches |
| snpValid | input | 1 | A transaction from another cache is on the bus |
| snpCmd | input | 2 | Snooped command, same codes as busCmd |
| snpAddr | input | AW | Snooped block address |
| shrOut | output | 1 | This cache holds the snooped block (reads only) |
| flushOut | output | 1 | This cache supplies the snooped block's data |

## Verification
Line state is never driven to a port, so a wrong state only shows up at the next event that touches the line. A lost exclusive turns the next write into an upgrade. A lost owned state drops the supplier flag on the next snooped read. A stale valid copy raises the shared output where it should stay low. A missed dirty state removes a writeback on replacement. Every step of the stimulus is therefore followed by a snoop or processor access that exposes the state it left, and that state shows within a few cycles at the bus request, the shared output or the supplier flag.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPGR = 2'd2,
    CMD_WB   = 2'd3
  } busCmd_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LOOK,
    F_EVICT,
    F_ACQ,
    F_SAMP,
    F_DONE
  } fsm_t;

  // strobes from the request control into the line store
  typedef struct packed {
    logic       we;
    logic       setTag;
    lineState_t newState;
  } ctrlStrobe_t;

  function automatic logic isDirty(lineState_t s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INDEX_W-1:0] reqIdx,
  output lineState_t         reqState,
  output logic [TAG_W-1:0]   reqTag,
  input  logic [INDEX_W-1:0] snpIdx,
  output lineState_t         snpState,
  output logic [TAG_W-1:0]   snpTag,
  input  ctrlStrobe_t        cpuStb,
  input  logic [TAG_W-1:0]   cpuNewTag,
  input  logic               snpWe,
  input  lineState_t         snpNewState
);
  localparam int LINES = 1 << INDEX_W;

  lineState_t       stateArr [LINES];
  logic [TAG_W-1:0] tagArr   [LINES];
  logic [LINES-1:0] cpuHitLine;
  logic [LINES-1:0] snpHitLine;

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign cpuHitLine[g] = cpuStb.we && (reqIdx == INDEX_W'(g));
    assign snpHitLine[g] = snpWe && (snpIdx == INDEX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= ST_I;
        tagArr[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        // processor-side update wins a same-line collision
        if (cpuHitLine[i]) begin
          stateArr[i] <= cpuStb.newState;
          if (cpuStb.setTag) tagArr[i] <= cpuNewTag;
        end else if (snpHitLine[i]) begin
          stateArr[i] <= snpNewState;
        end
      end
    end
  end

  assign reqState = stateArr[reqIdx];
  assign reqTag   = tagArr[reqIdx];
  assign snpState = stateArr[snpIdx];
  assign snpTag   = tagArr[snpIdx];

  // R8: a snoop update with no processor collision is visible next cycle
  a_r8_snoop_update_lands: assert property (@(posedge clk) disable iff (!rstN)
    (snpWe && !(cpuStb.we && reqIdx == snpIdx))
    |=> stateArr[$past(snpIdx)] == $past(snpNewState));
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int AW      = 8,
  parameter int INDEX_W = 3,
  localparam int TAG_W  = AW - INDEX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               snpValid,
  input  logic [1:0]         snpCmd,
  input  logic [AW-1:0]      snpAddr,
  output logic [INDEX_W-1:0] snpIdx,
  input  lineState_t         lineState,
  input  logic [TAG_W-1:0]   lineTag,
  output logic               snpWe,
  output lineState_t         snpNewState,
  output logic               shrOut,
  output logic               flushOut
);
  busCmd_t cmd;
  logic    hit;
  logic    dirty;

  assign cmd    = busCmd_t'(snpCmd);
  assign snpIdx = snpAddr[INDEX_W-1:0];
  assign hit    = snpValid && (lineState != ST_I) && (lineTag == snpAddr[AW-1:INDEX_W]);
  assign dirty  = isDirty(lineState);
  assign snpWe  = hit && (cmd != CMD_WB);

  always_comb begin
    snpNewState = lineState;
    unique case (cmd)
      CMD_RD: begin
        if (lineState == ST_M) snpNewState = ST_O;
        else if (lineState == ST_E) snpNewState = ST_S;
      end
      CMD_RDX, CMD_UPGR: snpNewState = ST_I;
      default: snpNewState = lineState;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shrOut   <= 1'b0;
      flushOut <= 1'b0;
    end else begin
      shrOut   <= hit && (cmd == CMD_RD);
      flushOut <= hit && dirty && ((cmd == CMD_RD) || (cmd == CMD_RDX));
    end
  end

  // R5: an owned copy keeps answering reads
  a_r5_owned_supplies: assert property (@(posedge clk) disable iff (!rstN)
    (hit && lineState == ST_O && cmd == CMD_RD) |=> (flushOut && shrOut));
  // R8: clean copies never supply data
  a_r8_clean_silent: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (lineState == ST_S || lineState == ST_E || lineState == ST_I)) |=> !flushOut);
endmodule

// File: rtl/moesi_req_ctrl.sv
module moesi_req_ctrl
  import moesi_pkg::*;
#(
  parameter int AW      = 8,
  parameter int INDEX_W = 3,
  localparam int TAG_W  = AW - INDEX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuWr,
  input  logic [AW-1:0]      cpuAddr,
  output logic               cpuDone,
  input  logic               snpValid,
  output logic [INDEX_W-1:0] reqIdx,
  input  lineState_t         lineState,
  input  logic [TAG_W-1:0]   lineTag,
  output ctrlStrobe_t        cpuStb,
  output logic [TAG_W-1:0]   cpuNewTag,
  output logic               busReq,
  output logic [1:0]         busCmd,
  output logic [AW-1:0]      busAddr,
  input  logic               busGnt,
  input  logic               shrIn
);
  fsm_t          fsm, fsmNext;
  logic          reqWr;
  logic [AW-1:0] reqAddr;
  busCmd_t       fillCmd, acqCmd;
  logic          tagMatch, hit;

  assign reqIdx    = reqAddr[INDEX_W-1:0];
  assign cpuNewTag = reqAddr[AW-1:INDEX_W];
  assign tagMatch  = (lineTag == reqAddr[AW-1:INDEX_W]);
  assign hit       = tagMatch && (lineState != ST_I);
  assign cpuDone   = (fsm == F_DONE);

  // command is re-derived every cycle so a snoop while waiting is honoured
  always_comb begin
    if (hit && (lineState == ST_S || lineState == ST_O)) acqCmd = CMD_UPGR;
    else if (reqWr) acqCmd = CMD_RDX;
    else acqCmd = CMD_RD;
  end

  always_comb begin
    fsmNext = fsm;
    cpuStb  = '{we: 1'b0, setTag: 1'b0, newState: ST_I};
    busReq  = 1'b0;
    busCmd  = CMD_RD;
    busAddr = reqAddr;
    unique case (fsm)
      F_IDLE: if (cpuReq) fsmNext = F_LOOK;
      F_LOOK: begin
        if (!snpValid) begin
          if (hit && (!reqWr || lineState == ST_M || lineState == ST_E)) begin
            cpuStb.we       = 1'b1;
            cpuStb.newState = reqWr ? ST_M : lineState;
            fsmNext         = F_DONE;
          end else if (!tagMatch && isDirty(lineState)) begin
            fsmNext = F_EVICT;
          end else begin
            fsmNext = F_ACQ;
          end
        end
      end
      F_EVICT: begin
        if (!isDirty(lineState)) begin
          fsmNext = F_ACQ;
        end else begin
          busReq  = 1'b1;
          busCmd  = CMD_WB;
          busAddr = {lineTag, reqIdx};
          if (busGnt) begin
            cpuStb.we       = 1'b1;
            cpuStb.newState = ST_I;
            fsmNext         = F_ACQ;
          end
        end
      end
      F_ACQ: begin
        busReq = 1'b1;
        busCmd = acqCmd;
        if (busGnt) fsmNext = F_SAMP;
      end
      F_SAMP: begin
        cpuStb.we       = 1'b1;
        cpuStb.setTag   = 1'b1;
        cpuStb.newState = (fillCmd == CMD_RD) ? (shrIn ? ST_S : ST_E) : ST_M;
        fsmNext         = F_DONE;
      end
      F_DONE: fsmNext = F_IDLE;
      default: fsmNext = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm     <= F_IDLE;
      reqWr   <= 1'b0;
      reqAddr <= '0;
      fillCmd <= CMD_RD;
    end else begin
      fsm <= fsmNext;
      if (fsm == F_IDLE && cpuReq) begin
        reqWr   <= cpuWr;
        reqAddr <= cpuAddr;
      end
      if (fsm == F_ACQ && busGnt) fillCmd <= acqCmd;
    end
  end

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  // R9: a writeback is only requested for a dirty victim
  a_r9_wb_only_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd == CMD_WB) |-> isDirty(lineState));
  // R3: a write hit on an exclusive line never reaches the bus
  a_r3_excl_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == F_LOOK && !snpValid && reqWr && hit && lineState == ST_E) |=> (!busReq && cpuDone));
  // R1: a granted fill request is followed by the sample cycle, not another request
  a_r1_grant_then_sample: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd != CMD_WB) |=> !busReq);
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int AW      = 8,
  parameter int INDEX_W = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWr,
  input  logic [AW-1:0] cpuAddr,
  output logic          cpuDone,
  output logic          busReq,
  output logic [1:0]    busCmd,
  output logic [AW-1:0] busAddr,
  input  logic          busGnt,
  input  logic          shrIn,
  input  logic          snpValid,
  input  logic [1:0]    snpCmd,
  input  logic [AW-1:0] snpAddr,
  output logic          shrOut,
  output logic          flushOut
);
  localparam int TAG_W = AW - INDEX_W;

  logic [INDEX_W-1:0] reqIdx, snpIdx;
  lineState_t         reqState, snpState, snpNewState;
  logic [TAG_W-1:0]   reqTag, snpTag, cpuNewTag;
  ctrlStrobe_t        cpuStb;
  logic               snpWe;

  moesi_req_ctrl #(.AW(AW), .INDEX_W(INDEX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuDone(cpuDone),
    .snpValid(snpValid),
    .reqIdx(reqIdx), .lineState(reqState), .lineTag(reqTag),
    .cpuStb(cpuStb), .cpuNewTag(cpuNewTag),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr),
    .busGnt(busGnt), .shrIn(shrIn)
  );

  moesi_snoop_unit #(.AW(AW), .INDEX_W(INDEX_W)) u_snoop (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpIdx(snpIdx), .lineState(snpState), .lineTag(snpTag),
    .snpWe(snpWe), .snpNewState(snpNewState),
    .shrOut(shrOut), .flushOut(flushOut)
  );

  moesi_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rstN(rstN),
    .reqIdx(reqIdx), .reqState(reqState), .reqTag(reqTag),
    .snpIdx(snpIdx), .snpState(snpState), .snpTag(snpTag),
    .cpuStb(cpuStb), .cpuNewTag(cpuNewTag),
    .snpWe(snpWe), .snpNewState(snpNewState)
  );
endmodule

// File: tb/moesi_snoop_ctrl_bench.sv
module moesi_snoop_ctrl_bench;
  localparam int AW = 8;
  localparam logic [2:0] NONE = 3'd4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWr = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cpuDone;
  logic          busReq;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic          busGnt = 1'b0, shrIn = 1'b0;
  logic          snpValid = 1'b0;
  logic [1:0]    snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic          shrOut, flushOut;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  moesi_snoop_ctrl u_moesi_snoop_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuDone(cpuDone), .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr),
    .busGnt(busGnt), .shrIn(shrIn), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .shrOut(shrOut), .flushOut(flushOut)
  );

  // kind: 0 read, 1 write, 2 snoop; shrMode: 0 low, 1 high, 2 high at grant only, 3 high at sample only
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] sCmd;
    logic [7:0] addr;
    logic [1:0] shrMode;
    logic [2:0] exp1;
    logic [2:0] exp2;
    logic       expShr;
    logic       expFlush;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 8'h10, 2'd0, 3'd0, NONE, 1'b0, 1'b0, 4'd1},  // R1 miss, exclusive fill
    '{2'd1, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd3},  // R3 E write is silent
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b1, 1'b1, 4'd4},  // R4 M read by other -> O
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b1, 1'b1, 4'd5},  // R5 O keeps supplying
    '{2'd1, 2'd0, 8'h10, 2'd0, 3'd2, NONE, 1'b0, 1'b0, 4'd7},  // R7 O write upgrades
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b1, 1'b1, 4'd4},  // R4 M -> O again
    '{2'd2, 2'd1, 8'h10, 2'd0, NONE, NONE, 1'b0, 1'b1, 4'd6},  // R6 O sees RDX -> I
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd2},  // R2 invalid copy quiet
    '{2'd0, 2'd0, 8'h10, 2'd1, 3'd0, NONE, 1'b0, 1'b0, 4'd1},  // R1 shared fill
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b1, 1'b0, 4'd2},  // R2 S answers shared
    '{2'd1, 2'd0, 8'h10, 2'd0, 3'd2, NONE, 1'b0, 1'b0, 4'd7},  // R7 S write upgrades
    '{2'd0, 2'd0, 8'h18, 2'd0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd9},  // R9 dirty victim written back
    '{2'd2, 2'd0, 8'h10, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd2},  // R2 tag mismatch quiet
    '{2'd2, 2'd0, 8'h18, 2'd0, NONE, NONE, 1'b1, 1'b0, 4'd8},  // R8 E read by other -> S
    '{2'd0, 2'd0, 8'h18, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd11}, // R11 read hit no bus
    '{2'd1, 2'd0, 8'h18, 2'd0, 3'd2, NONE, 1'b0, 1'b0, 4'd7},  // R7 confirms S
    '{2'd2, 2'd0, 8'h18, 2'd0, NONE, NONE, 1'b1, 1'b1, 4'd4},  // R4 M -> O
    '{2'd0, 2'd0, 8'h10, 2'd0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd9},  // R9 owned victim written back
    '{2'd2, 2'd2, 8'h10, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd8},  // R8 upgrade kills E
    '{2'd0, 2'd0, 8'h10, 2'd0, 3'd0, NONE, 1'b0, 1'b0, 4'd8},  // R8 confirms I
    '{2'd1, 2'd0, 8'h21, 2'd0, 3'd1, NONE, 1'b0, 1'b0, 4'd11}, // R11 write miss RDX
    '{2'd0, 2'd0, 8'h18, 2'd1, 3'd0, NONE, 1'b0, 1'b0, 4'd9},  // R9 clean victim silent
    '{2'd2, 2'd1, 8'h18, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd8},  // R8 RDX kills S, no data
    '{2'd0, 2'd0, 8'h18, 2'd0, 3'd0, NONE, 1'b0, 1'b0, 4'd8},  // R8 confirms I
    '{2'd2, 2'd0, 8'h21, 2'd0, NONE, NONE, 1'b1, 1'b1, 4'd4},  // R4 M -> O
    '{2'd2, 2'd2, 8'h21, 2'd0, NONE, NONE, 1'b0, 1'b0, 4'd8},  // R8 upgrade kills O
    '{2'd1, 2'd0, 8'h21, 2'd0, 3'd1, NONE, 1'b0, 1'b0, 4'd8}   // R8 confirms I
  };

  task automatic check(input logic ok, input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpuOp(input logic wr, input logic [7:0] addr, input logic [1:0] mode,
                       input logic [2:0] exp1, input logic [2:0] exp2, input int req);
    logic [2:0] got [2];
    int         n = 0;
    logic       done = 1'b0;
    got[0] = NONE;
    got[1] = NONE;
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = wr; cpuAddr = addr; shrIn = (mode == 2'd1);
    @(negedge clk);
    cpuReq = 1'b0;
    for (int c = 0; c < 40 && !done; c++) begin
      if (cpuDone) begin
        done = 1'b1;
      end else begin
        if (busGnt) begin
          busGnt = 1'b0;
          shrIn  = (mode == 2'd1) || (mode == 2'd3);
        end else if (busReq) begin
          if (n < 2) got[n] = {1'b0, busCmd};
          if (busCmd != 2'd3) check(busAddr == addr, req, "bus address", busAddr, addr);
          n++;
          busGnt = 1'b1;
          shrIn  = (mode == 2'd1) || (mode == 2'd2);
        end
        @(negedge clk);
      end
    end
    shrIn = 1'b0;
    check(done, req, "request completion", {7'd0, done}, 8'd1);
    check(got[0] == exp1, req, "first bus command", {5'd0, got[0]}, {5'd0, exp1});
    check(got[1] == exp2, req, "second bus command", {5'd0, got[1]}, {5'd0, exp2});
    @(negedge clk);
    check(!cpuDone, req, "done pulse width", {7'd0, cpuDone}, 8'd0);
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [7:0] addr,
                         input logic eShr, input logic eFl, input int req);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = addr;
    @(negedge clk);
    snpValid = 1'b0;
    check(shrOut == eShr, req, "shared output", {7'd0, shrOut}, {7'd0, eShr});
    check(flushOut == eFl, req, "supplier flag", {7'd0, flushOut}, {7'd0, eFl});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: idle outputs after reset
    check(!busReq && !cpuDone && !shrOut && !flushOut, 12, "outputs after reset",
          {4'd0, busReq, cpuDone, shrOut, flushOut}, 8'd0);
    // R12: every line invalid: snoop reads on all indices stay quiet
    for (int i = 0; i < 8; i++) snoopOp(2'd0, 8'(i), 1'b0, 1'b0, 12);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].kind == 2'd2)
        snoopOp(VEC[v].sCmd, VEC[v].addr, VEC[v].expShr, VEC[v].expFlush, int'(VEC[v].req));
      else
        cpuOp(VEC[v].kind[0], VEC[v].addr, VEC[v].shrMode, VEC[v].exp1, VEC[v].exp2,
              int'(VEC[v].req));
    end

    // R10: shared high only during grant is ignored -> exclusive, write is silent
    cpuOp(1'b0, 8'h22, 2'd2, 3'd0, NONE, 10);
    cpuOp(1'b1, 8'h22, 2'd0, NONE, NONE, 10);
    // R10: shared high only in the sample cycle -> shared, write upgrades
    cpuOp(1'b0, 8'h23, 2'd3, 3'd0, NONE, 10);
    cpuOp(1'b1, 8'h23, 2'd0, 3'd2, NONE, 10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule